// File: doc/BRIEF.md
# Rotating Multi-Scheduler Dual-Issue Warp Issue Stage

This block picks which warps send instructions into a core's execution pipes in each cycle. The core's warps are split evenly among several schedulers. Each scheduler looks at the head instruction of every warp it owns. It picks the oldest warp that can issue, judged by an age stamp given at launch, and may send up to two instructions from that one warp. There are three pipes: arithmetic, special-function and memory. Each pipe tells the block how many free input slots it has this cycle. Those slots are shared, so the schedulers claim them one after another.

The schedulers do not take turns in a fixed order. A rotation index picks which scheduler goes first. That scheduler claims pipe slots first, the next one claims from what is left, and so on. The index moves on by one every cycle. The block's decisions are combinational from its inputs within the cycle. Only three things are registered: the rotation index, the warp age table with its launch counter, and a counter of dual-issue events.

Each scheduler's decision has three outcomes. IDLE means no warp could issue. SINGLE means the chosen warp's head instruction issued alone. DUAL means the head and the instruction after it both issued. A scheduler moves from IDLE to SINGLE when a warp is eligible. It moves from SINGLE to DUAL when the second instruction passes its own checks. The rotation index steps from each value to the next and wraps from the last scheduler back to the first.

Top module: `warp_issue_core`

## Requirements
- R1: After reset the rotation index is 0. It rises by one every cycle and wraps to 0 after NS-1. Position i of the rotation serves scheduler (index + i) mod NS.
- R2: Among a scheduler's eligible warps, the oldest one issues. When two ages are equal, the lower local index wins.
- R3: A warp whose waiting flag is set, or whose buffer-empty flag is set, issues nothing.
- R4: A head instruction issues only if its ready flag is set, its pipe code is 0 (arithmetic), 1 (special) or 2 (memory), and its pipe still has a free slot. Code 3 never issues.
- R5: The second instruction issues only if all of these hold: MAX_ISSUE is 2, the head of the same warp issued this cycle, the second-present flag is set, the second ready flag is set, and its pipe still has a slot. A stalled head therefore blocks the second instruction.
- R6: With DIFF_UNITS set, the second instruction must use a pipe code different from the head's. With DIFF_UNITS clear, both instructions may use the same pipe.
- R7: Pipe slots are claimed in rotation order. A scheduler later in the rotation only sees the slots that earlier schedulers left over.
- R8: Each launch pulse stamps the warp with the value of a wrapping AGE_W-bit counter. The counter then advances. Several launches in one cycle are stamped in ascending warp index order. Age a is older than age b when bit AGE_W-1 of (a - b) is set.
- R9: `dual_count` rises at each clock edge by the number of schedulers whose outcome was DUAL in that cycle. It wraps.
- R10: Reset clears `dual_count`, the rotation index, all ages and the launch counter.
- R11: The 2-bit field p of `pipe_take` (bits 2p+1:2p) equals the number of instructions sent to pipe p in this cycle. It never exceeds that pipe's free slots. The fields of `pipe_take` add up to the sum of the `sch_cnt` fields.
- R12: Scheduler s reports its issue count on `sch_cnt[2s+1:2s]` and its chosen local warp on `sch_warp` (LW bits per scheduler). Both are 0 when the scheduler is IDLE. Global warp index = s*WPS + local index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_launch | input | NS*WPS | Launch pulse per warp; stamps its age |
| warp_wait | input | NS*WPS | Warp is waiting and may not issue |
| warp_empty | input | NS*WPS | Warp's instruction buffer is empty |
| warp_has2 | input | NS*WPS | A second instruction is present behind the head |
| ins0_rdy | input | NS*WPS | Head instruction operands ready |
| ins0_pipe | input | 2*NS*WPS | Head pipe code (0 arith, 1 special, 2 memory, 3 none) |
| ins1_rdy | input | NS*WPS | Second instruction operands ready |
| ins1_pipe | input | 2*NS*WPS | Second instruction pipe code |
| pipe_room | input | 6 | Free input slots per pipe, 2 bits each |
| pipe_take | output | 6 | Instructions entering each pipe, 2 bits each |
| sch_cnt | output | 2*NS | Instructions issued by each scheduler |
| sch_warp | output | NS*LW | Local warp chosen by each scheduler |
| dual_count | output | CNT_W | Wrapping count of dual-issue events |

## Verification
The bench builds three copies with NS=2, WPS=4, AGE_W=4 and drives them with the same stimulus. The copies differ only in issue configuration: dual issue with distinct pipes, dual issue allowing the same pipe, and single issue only. Comparing them shows the effect of the second-instruction rules directly. A 4-bit age lets a few launch cycles push the launch counter past its wrap, so the wrap-safe age comparison is tested against a naive numeric one. Two schedulers contending for a single slot show the rotation passing priority back and forth from one cycle to the next.

// File: rtl/issue_pkg.sv
`timescale 1ns/1ps
package issue_pkg;
    localparam int NPIPE = 3;
    localparam logic [1:0] PIPE_ARITH = 2'd0;
    localparam logic [1:0] PIPE_SPEC  = 2'd1;
    localparam logic [1:0] PIPE_MEMRY = 2'd2;
    localparam logic [1:0] PIPE_NONE  = 2'd3;

    // Slot 3 stands for "no pipe" and always holds zero room.
    typedef logic [3:0][1:0] room_t;

    typedef enum logic [1:0] {
        ISS_IDLE   = 2'd0,
        ISS_SINGLE = 2'd1,
        ISS_DUAL   = 2'd2
    } iss_e;
endpackage

// File: rtl/rot_ring.sv
`timescale 1ns/1ps
module rot_ring #(
    parameter int NS = 2,
    localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [SW-1:0] rot_idx
);
    logic [SW-1:0] rot_q;
    logic [SW-1:0] rot_d;

    always_comb begin
        if (rot_q == SW'(NS - 1)) rot_d = '0;
        else                      rot_d = rot_q + SW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rot_q <= '0;
        else        rot_q <= rot_d;
    end

    assign rot_idx = rot_q;
endmodule

// File: rtl/age_table.sv
`timescale 1ns/1ps
module age_table #(
    parameter int NW    = 8,
    parameter int AGE_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NW-1:0]             launch,
    output logic [NW-1:0][AGE_W-1:0]  ages
);
    logic [AGE_W-1:0]            ctr_q, ctr_d;
    logic [NW-1:0][AGE_W-1:0]    age_q, age_d;

    always_comb begin
        logic [AGE_W-1:0] run;
        run   = ctr_q;
        age_d = age_q;
        for (int w = 0; w < NW; w++) begin
            if (launch[w]) begin
                age_d[w] = run;
                run      = run + AGE_W'(1);
            end
        end
        ctr_d = run;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q <= '0;
            age_q <= '0;
        end else begin
            ctr_q <= ctr_d;
            age_q <= age_d;
        end
    end

    assign ages = age_q;
endmodule

// File: rtl/issue_stage.sv
`timescale 1ns/1ps
module issue_stage
    import issue_pkg::*;
#(
    parameter int WPS        = 4,
    parameter int AGE_W      = 4,
    parameter int MAX_ISSUE  = 2,
    parameter bit DIFF_UNITS = 1'b1,
    localparam int LW = (WPS > 1) ? $clog2(WPS) : 1
) (
    input  logic [WPS-1:0]             w_wait,
    input  logic [WPS-1:0]             w_empty,
    input  logic [WPS-1:0]             w_has2,
    input  logic [WPS-1:0]             r0,
    input  logic [WPS-1:0]             r1,
    input  logic [WPS-1:0][1:0]        p0,
    input  logic [WPS-1:0][1:0]        p1,
    input  logic [WPS-1:0][AGE_W-1:0]  age,
    input  room_t                      room_in,
    output room_t                      room_out,
    output logic [1:0]                 cnt,
    output logic [LW-1:0]              sel
);
    logic [WPS-1:0]   elig;
    logic             found;
    logic [LW-1:0]    best;
    logic [AGE_W-1:0] best_age;
    room_t            room_mid;
    room_t            room_two;
    logic             sec_ok;
    iss_e             outcome;

    function automatic logic is_older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
        logic [AGE_W-1:0] d;
        d = a - b;
        return d[AGE_W-1];
    endfunction

    always_comb begin
        for (int k = 0; k < WPS; k++) begin
            elig[k] = !w_wait[k] && !w_empty[k] && r0[k] &&
                      (p0[k] != PIPE_NONE) && (room_in[p0[k]] != 2'd0);
        end
    end

    // Oldest eligible warp; ties keep the lower index.
    always_comb begin
        found    = 1'b0;
        best     = '0;
        best_age = '0;
        for (int k = 0; k < WPS; k++) begin
            if (elig[k] && (!found || is_older(age[k], best_age))) begin
                found    = 1'b1;
                best     = LW'(k);
                best_age = age[k];
            end
        end
    end

    always_comb begin
        room_mid = room_in;
        if (found) room_mid[p0[best]] = room_in[p0[best]] - 2'd1;
        sec_ok = found && (MAX_ISSUE > 1) && w_has2[best] && r1[best] &&
                 (p1[best] != PIPE_NONE) && (room_mid[p1[best]] != 2'd0) &&
                 (!DIFF_UNITS || (p1[best] != p0[best]));
        room_two = room_mid;
        if (sec_ok) room_two[p1[best]] = room_mid[p1[best]] - 2'd1;
    end

    always_comb begin
        if (!found)      outcome = ISS_IDLE;
        else if (sec_ok) outcome = ISS_DUAL;
        else             outcome = ISS_SINGLE;
    end

    always_comb begin
        unique case (outcome)
            ISS_IDLE: begin
                room_out = room_in;
                cnt      = 2'd0;
                sel      = '0;
            end
            ISS_SINGLE: begin
                room_out = room_mid;
                cnt      = 2'd1;
                sel      = best;
            end
            ISS_DUAL: begin
                room_out = room_two;
                cnt      = 2'd2;
                sel      = best;
            end
            default: begin
                room_out = room_in;
                cnt      = 2'd0;
                sel      = '0;
            end
        endcase
    end
endmodule

// File: rtl/warp_issue_core.sv
`timescale 1ns/1ps
module warp_issue_core
    import issue_pkg::*;
#(
    parameter int NS         = 2,
    parameter int WPS        = 4,
    parameter int AGE_W      = 4,
    parameter int MAX_ISSUE  = 2,
    parameter bit DIFF_UNITS = 1'b1,
    parameter int CNT_W      = 16
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [NS*WPS-1:0]                           warp_launch,
    input  logic [NS*WPS-1:0]                           warp_wait,
    input  logic [NS*WPS-1:0]                           warp_empty,
    input  logic [NS*WPS-1:0]                           warp_has2,
    input  logic [NS*WPS-1:0]                           ins0_rdy,
    input  logic [2*NS*WPS-1:0]                         ins0_pipe,
    input  logic [NS*WPS-1:0]                           ins1_rdy,
    input  logic [2*NS*WPS-1:0]                         ins1_pipe,
    input  logic [5:0]                                  pipe_room,
    output logic [5:0]                                  pipe_take,
    output logic [2*NS-1:0]                             sch_cnt,
    output logic [NS*((WPS > 1) ? $clog2(WPS) : 1)-1:0] sch_warp,
    output logic [CNT_W-1:0]                            dual_count
);
    localparam int NW = NS * WPS;
    localparam int LW = (WPS > 1) ? $clog2(WPS) : 1;
    localparam int SW = (NS > 1) ? $clog2(NS) : 1;

    logic [SW-1:0]                       rot_idx;
    logic [NW-1:0][AGE_W-1:0]            ages;
    logic [NS-1:0][SW-1:0]               pos_s;
    logic [NS-1:0][WPS-1:0]              g_wait, g_empty, g_has2, g_r0, g_r1;
    logic [NS-1:0][WPS-1:0][1:0]         g_p0, g_p1;
    logic [NS-1:0][WPS-1:0][AGE_W-1:0]   g_age;
    room_t                               room [NS+1];
    logic [NS-1:0][1:0]                  pos_cnt;
    logic [NS-1:0][LW-1:0]               pos_sel;
    logic [CNT_W-1:0]                    n_dual;
    logic [CNT_W-1:0]                    dual_q;

    rot_ring #(.NS(NS)) u_rot (
        .clk     (clk),
        .rst_n   (rst_n),
        .rot_idx (rot_idx)
    );

    age_table #(.NW(NW), .AGE_W(AGE_W)) u_age (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (warp_launch),
        .ages   (ages)
    );

    // Route each scheduler's warps to its slot in this cycle's rotation.
    always_comb begin
        for (int i = 0; i < NS; i++) begin
            int t;
            t = int'(rot_idx) + i;
            if (t >= NS) t = t - NS;
            pos_s[i] = SW'(t);
            for (int k = 0; k < WPS; k++) begin
                int w;
                w = t * WPS + k;
                g_wait[i][k]  = warp_wait[w];
                g_empty[i][k] = warp_empty[w];
                g_has2[i][k]  = warp_has2[w];
                g_r0[i][k]    = ins0_rdy[w];
                g_r1[i][k]    = ins1_rdy[w];
                g_p0[i][k]    = ins0_pipe[w*2 +: 2];
                g_p1[i][k]    = ins1_pipe[w*2 +: 2];
                g_age[i][k]   = ages[w];
            end
        end
    end

    assign room[0] = {2'b00, pipe_room};

    for (genvar i = 0; i < NS; i++) begin : g_pos
        issue_stage #(
            .WPS        (WPS),
            .AGE_W      (AGE_W),
            .MAX_ISSUE  (MAX_ISSUE),
            .DIFF_UNITS (DIFF_UNITS)
        ) u_stage (
            .w_wait   (g_wait[i]),
            .w_empty  (g_empty[i]),
            .w_has2   (g_has2[i]),
            .r0       (g_r0[i]),
            .r1       (g_r1[i]),
            .p0       (g_p0[i]),
            .p1       (g_p1[i]),
            .age      (g_age[i]),
            .room_in  (room[i]),
            .room_out (room[i+1]),
            .cnt      (pos_cnt[i]),
            .sel      (pos_sel[i])
        );
    end

    // Map rotation positions back to scheduler numbering.
    always_comb begin
        sch_cnt  = '0;
        sch_warp = '0;
        for (int s = 0; s < NS; s++) begin
            for (int i = 0; i < NS; i++) begin
                if (pos_s[i] == SW'(s)) begin
                    sch_cnt[s*2 +: 2]   = pos_cnt[i];
                    sch_warp[s*LW +: LW] = pos_sel[i];
                end
            end
        end
    end

    always_comb begin
        for (int p = 0; p < NPIPE; p++) begin
            pipe_take[p*2 +: 2] = room[0][p] - room[NS][p];
        end
    end

    always_comb begin
        n_dual = '0;
        for (int i = 0; i < NS; i++) begin
            if (pos_cnt[i] == 2'd2) n_dual = n_dual + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dual_q <= '0;
        else        dual_q <= dual_q + n_dual;
    end

    assign dual_count = dual_q;
endmodule

// File: rtl/warp_issue_chk.sv
`timescale 1ns/1ps
module warp_issue_chk #(
    parameter int NS        = 2,
    parameter int WPS       = 4,
    parameter int MAX_ISSUE = 2,
    parameter int CNT_W     = 16,
    localparam int LW = (WPS > 1) ? $clog2(WPS) : 1,
    localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NS*WPS-1:0]  warp_wait,
    input logic [NS*WPS-1:0]  warp_empty,
    input logic [5:0]         pipe_room,
    input logic [5:0]         pipe_take,
    input logic [2*NS-1:0]    sch_cnt,
    input logic [NS*LW-1:0]   sch_warp,
    input logic [CNT_W-1:0]   dual_count,
    input logic [SW-1:0]      rot_idx
);
    logic [7:0]       take_sum, cnt_sum;
    logic [CNT_W-1:0] nd;

    always_comb begin
        take_sum = '0;
        cnt_sum  = '0;
        nd       = '0;
        for (int p = 0; p < 3; p++) take_sum = take_sum + 8'(pipe_take[p*2 +: 2]);
        for (int s = 0; s < NS; s++) begin
            cnt_sum = cnt_sum + 8'(sch_cnt[s*2 +: 2]);
            if (sch_cnt[s*2 +: 2] == 2'd2) nd = nd + CNT_W'(1);
        end
    end

    assert_rot_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rot_idx == (($past(rot_idx) == SW'(NS - 1)) ? SW'(0) : $past(rot_idx) + SW'(1)));

    assert_take_total_R11: assert property (@(posedge clk) disable iff (!rst_n)
        take_sum == cnt_sum);

    assert_dual_tally_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> dual_count == $past(dual_count) + $past(nd));

    for (genvar p = 0; p < 3; p++) begin : g_pp
        assert_take_room_R11: assert property (@(posedge clk) disable iff (!rst_n)
            pipe_take[p*2 +: 2] <= pipe_room[p*2 +: 2]);
    end

    for (genvar s = 0; s < NS; s++) begin : g_ss
        assert_no_blocked_warp_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (sch_cnt[s*2 +: 2] != 2'd0) |->
            (!warp_wait[s*WPS + int'(sch_warp[s*LW +: LW])] &&
             !warp_empty[s*WPS + int'(sch_warp[s*LW +: LW])]));

        assert_issue_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
            int'(sch_cnt[s*2 +: 2]) <= MAX_ISSUE);
    end
endmodule

bind warp_issue_core warp_issue_chk #(
    .NS        (NS),
    .WPS       (WPS),
    .MAX_ISSUE (MAX_ISSUE),
    .CNT_W     (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .warp_wait  (warp_wait),
    .warp_empty (warp_empty),
    .pipe_room  (pipe_room),
    .pipe_take  (pipe_take),
    .sch_cnt    (sch_cnt),
    .sch_warp   (sch_warp),
    .dual_count (dual_count),
    .rot_idx    (rot_idx)
);

// File: tb/sim_warp_issue_core.sv
`timescale 1ns/1ps
module sim_warp_issue_core;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [7:0]  launch = '0, wt = '1, em = '0, h2 = '0, r0 = '0, r1 = '0;
    logic [15:0] p0 = '0, p1 = '0;
    logic [5:0]  room = 6'b101010;
    logic [7:0]  n_launch, n_wt, n_em, n_h2, n_r0, n_r1;
    logic [15:0] n_p0, n_p1;
    logic [5:0]  n_room;

    logic [5:0] take0, take1, take2;
    logic [3:0] cnt0, cnt1, cnt2, wrp0, wrp1, wrp2;
    logic [7:0] dual0, dual1, dual2;

    warp_issue_core #(.NS(2), .WPS(4), .AGE_W(4), .MAX_ISSUE(2), .DIFF_UNITS(1'b1), .CNT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .warp_launch(launch), .warp_wait(wt), .warp_empty(em),
        .warp_has2(h2), .ins0_rdy(r0), .ins0_pipe(p0), .ins1_rdy(r1), .ins1_pipe(p1),
        .pipe_room(room), .pipe_take(take0), .sch_cnt(cnt0), .sch_warp(wrp0), .dual_count(dual0));
    warp_issue_core #(.NS(2), .WPS(4), .AGE_W(4), .MAX_ISSUE(2), .DIFF_UNITS(1'b0), .CNT_W(8)) u1 (
        .clk(clk), .rst_n(rst_n), .warp_launch(launch), .warp_wait(wt), .warp_empty(em),
        .warp_has2(h2), .ins0_rdy(r0), .ins0_pipe(p0), .ins1_rdy(r1), .ins1_pipe(p1),
        .pipe_room(room), .pipe_take(take1), .sch_cnt(cnt1), .sch_warp(wrp1), .dual_count(dual1));
    warp_issue_core #(.NS(2), .WPS(4), .AGE_W(4), .MAX_ISSUE(1), .DIFF_UNITS(1'b1), .CNT_W(8)) u2 (
        .clk(clk), .rst_n(rst_n), .warp_launch(launch), .warp_wait(wt), .warp_empty(em),
        .warp_has2(h2), .ins0_rdy(r0), .ins0_pipe(p0), .ins1_rdy(r1), .ins1_pipe(p1),
        .pipe_room(room), .pipe_take(take2), .sch_cnt(cnt2), .sch_warp(wrp2), .dual_count(dual2));

    typedef struct {
        logic [3:0] cnt;
        logic [3:0] wrp;
        logic [5:0] take;
        logic [1:0] c_u1;
        logic [1:0] c_u2;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_fail = 0, cyc = 0;
    int   exp_dual = 0;
    bit   done = 1'b0;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic exp_t mk(input int c0, input int w0, input int c1, input int w1,
                                input logic [5:0] tk, input int u1c, input int u2c, input string tg);
        exp_t e;
        e.cnt = {2'(c1), 2'(c0)};
        e.wrp = {2'(w1), 2'(w0)};
        e.take = tk;
        e.c_u1 = 2'(u1c);
        e.c_u2 = 2'(u2c);
        e.tag = tg;
        return e;
    endfunction

    function automatic int prio_next();
        return (cyc + 1) % 2;
    endfunction

    task automatic clr();
        n_launch = '0; n_wt = '1; n_em = '0; n_h2 = '0; n_r0 = '0; n_r1 = '0;
        n_p0 = '0; n_p1 = '0; n_room = 6'b101010;
    endtask

    task automatic setw(input int w, input int pp0, input bit second, input int pp1);
        n_wt[w] = 1'b0;
        n_r0[w] = 1'b1;
        n_p0[w*2 +: 2] = 2'(pp0);
        n_h2[w] = second;
        n_r1[w] = second;
        n_p1[w*2 +: 2] = 2'(pp1);
    endtask

    // Driver: applies the staged stimulus and queues what it must produce.
    task automatic drive(input exp_t e);
        @(negedge clk);
        launch = n_launch; wt = n_wt; em = n_em; h2 = n_h2; r0 = n_r0; r1 = n_r1;
        p0 = n_p0; p1 = n_p1; room = n_room;
        q.push_back(e);
    endtask

    task automatic idle_launch(input int w);
        clr();
        n_launch[w] = 1'b1;
        drive(mk(0, 0, 0, 0, 6'b0, 0, 0, "R8"));
    endtask

    // Monitor: pops one expectation per cycle and compares.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(dual0 == 8'(exp_dual), "R9 dual_count", dual0, exp_dual);
                check(cnt0 == e.cnt, {e.tag, " sch_cnt"}, cnt0, e.cnt);
                check(wrp0 == e.wrp, {e.tag, " sch_warp"}, wrp0, e.wrp);
                check(take0 == e.take, {e.tag, " R11 pipe_take"}, take0, e.take);
                check(cnt1[1:0] == e.c_u1, {e.tag, " same-pipe copy"}, cnt1[1:0], e.c_u1);
                check(cnt2[1:0] == e.c_u2, {e.tag, " single-issue copy"}, cnt2[1:0], e.c_u2);
                exp_dual = exp_dual + ((e.cnt[1:0] == 2'd2) ? 1 : 0) + ((e.cnt[3:2] == 2'd2) ? 1 : 0);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int pr;
        clr();
        repeat (3) @(negedge clk);
        // R10: reset state
        check(dual0 == 8'd0 && dual1 == 8'd0 && dual2 == 8'd0, "R10 dual reset", dual0, 0);
        check(cnt0 == 4'd0 && take0 == 6'd0, "R10 idle in reset", cnt0, 0);
        rst_n = 1'b1;

        // R8: stamp ages 0..7, then relaunch to reorder and wrap the counter
        clr(); n_launch = 8'hFF;
        drive(mk(0, 0, 0, 0, 6'b0, 0, 0, "R8"));
        idle_launch(3); idle_launch(2); idle_launch(1); idle_launch(0);
        idle_launch(5); idle_launch(6); idle_launch(7); idle_launch(4); idle_launch(6);
        // ages now w0=11 w1=10 w2=9 w3=8 w4=15 w5=12 w6=0 w7=14

        // R2: oldest of four eligible warps (w3) wins
        clr(); setw(0, 0, 0, 0); setw(1, 0, 0, 0); setw(2, 0, 0, 0); setw(3, 0, 0, 0);
        drive(mk(1, 3, 0, 0, 6'b00_00_01, 1, 1, "R2"));

        // R5: dual issue arith + memory from w2
        clr(); setw(2, 0, 1, 2);
        drive(mk(2, 2, 0, 0, 6'b01_00_01, 2, 1, "R5"));

        // R6: second in the same pipe is held back only with distinct-pipe rule
        clr(); setw(2, 0, 1, 0);
        drive(mk(1, 2, 0, 0, 6'b00_00_01, 2, 1, "R6"));

        // R5: stalled head blocks the ready second instruction
        clr(); setw(2, 0, 1, 1); n_r0[2] = 1'b0;
        drive(mk(0, 0, 0, 0, 6'b0, 0, 0, "R5"));

        // R3: empty oldest warp and waiting warp are skipped
        clr(); setw(3, 0, 0, 0); n_em[3] = 1'b1; setw(1, 0, 0, 0); n_wt[1] = 1'b1; setw(0, 1, 0, 0);
        drive(mk(1, 0, 0, 0, 6'b00_01_00, 1, 1, "R3"));

        // R4: full pipe makes the oldest warp yield
        clr(); setw(3, 0, 0, 0); setw(2, 2, 0, 0); n_room = 6'b10_10_00;
        drive(mk(1, 2, 0, 0, 6'b01_00_00, 1, 1, "R4"));

        // R4: pipe code 3 never issues
        clr(); setw(3, 3, 0, 0); setw(0, 0, 0, 0);
        drive(mk(1, 0, 0, 0, 6'b00_00_01, 1, 1, "R4"));

        // R8: wrapped ages, 15 is older than 0 (w4 beats w6)
        clr(); setw(4, 1, 0, 0); setw(6, 1, 0, 0);
        drive(mk(0, 0, 1, 0, 6'b00_01_00, 0, 0, "R8"));

        // R1: one arith slot, winner follows the rotation over two cycles
        for (int n = 0; n < 2; n++) begin
            clr(); setw(3, 0, 0, 0); setw(4, 0, 0, 0); n_room = 6'b10_10_01;
            pr = prio_next();
            if (pr == 0) drive(mk(1, 3, 0, 0, 6'b00_00_01, 1, 1, "R1"));
            else         drive(mk(0, 0, 1, 0, 6'b00_00_01, 0, 0, "R1"));
        end

        // R9: both schedulers dual issue in one cycle
        clr(); setw(2, 0, 1, 2); setw(4, 1, 1, 2);
        drive(mk(2, 2, 2, 0, 6'b10_01_01, 2, 1, "R9"));

        // R7: one memory slot goes to the scheduler first in rotation
        clr(); setw(2, 0, 1, 2); setw(4, 1, 1, 2); n_room = 6'b01_10_10;
        pr = prio_next();
        if (pr == 0) drive(mk(2, 2, 1, 0, 6'b01_01_01, 2, 1, "R7"));
        else         drive(mk(1, 2, 2, 0, 6'b01_01_01, 1, 1, "R7"));

        // idle tail so the last dual count is observed
        clr();
        drive(mk(0, 0, 0, 0, 6'b0, 0, 0, "R12"));
        drive(mk(0, 0, 0, 0, 6'b0, 0, 0, "R12"));
        @(negedge clk);
        #2;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule